// File: doc/BRIEF.md
# CSR Write Flush Controller

This decode-stage unit sits in a small in-order core with a single fetch stage. It looks at each instruction word the decoder hands it and recognises the CSR access forms of the SYSTEM opcode. For each one it reports the kind of access (read, write, set or clear) and the 12-bit CSR address. It also works out whether the instruction really changes the CSR. A set or clear whose source field is zero only reads the CSR, so it is treated as a read.

Every real modification raises a single-cycle flush request toward fetch. The instruction fetched after the CSR write is then refetched and sees the new machine state; this costs one cycle. A short parameterised list of exempt addresses (by default the scratch register and the exception return address) skips the flush. The machine status register and every memory-protection configuration and address register always flush, even if someone places them on the exempt list. An instruction is taken only in a cycle where it is valid and not stalled. The results are registered, so they appear one cycle after the instruction is taken.

Top module: `csr_flush_ctrl`

## Requirements
- R1: An instruction is a CSR access only when bits [6:0] equal 7'b1110011 and funct3 (bits [14:12]) is 001, 010, 011, 101, 110 or 111. Funct3 000 or 100, and any other opcode, gives no write-enable and no flush. For an accepted CSR access, csr_addr_o carries instruction bits [31:20].
- R2: csr_op_o encodes the access as 2'b00 read, 2'b01 write, 2'b10 set and 2'b11 clear. Funct3 x01 means write, x10 means set and x11 means clear.
- R3: The write forms (funct3 001 and 101) always report write, with write-enable high, whatever the value of bits [19:15].
- R4: The set and clear forms (funct3 010, 011, 110, 111) with bits [19:15] equal to zero report read, with write-enable and flush low. With a nonzero field they report set or clear with write-enable high.
- R5: A modification of address 0x340 or 0x341 raises write-enable but not flush.
- R6: A modification of address 0x300, or of any address from 0x3A0 to 0x3EF, always raises flush. This includes clear forms.
- R7: A modification of any other address raises flush together with write-enable.
- R8: The outputs change on the clock edge after the edge at which valid_i is high and stall_i is low. Write-enable and flush are high for exactly that one cycle per accepted instruction. csr_op_o and csr_addr_o hold their last accepted values in other cycles.
- R9: While rst_ni is low, all outputs are zero.
- R10: An instruction presented with valid_i low, or with stall_i high, produces no write-enable and no flush. It is taken once in the first cycle it is valid and not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word in decode |
| valid_i | input | 1 | Instruction word is valid |
| stall_i | input | 1 | Decode stage is stalled; instruction not taken |
| csr_op_o | output | 2 | Registered CSR access kind |
| csr_addr_o | output | 12 | Registered CSR address |
| csr_we_o | output | 1 | Registered CSR write-enable pulse |
| flush_o | output | 1 | Registered fetch flush pulse |

## Verification
The hardest case is an instruction held on the input across several stalled cycles and then released. It must produce exactly one write-enable and flush pulse, neither early nor repeated. The stimulus holds protection and status writes under stall for several cycles, and also presents the same valid word on two consecutive unstalled cycles, which counts as two instructions. A second hard case is the boundary of the zero-source rule. Set and clear forms go in with the source field at zero and at its smallest nonzero value, against exempt, mandatory and ordinary addresses, so that each of the three flush decisions is reached from both the register and the immediate forms.

// File: rtl/csr_flush_pkg.sv
package csr_flush_pkg;

   typedef enum logic [1:0] {
      CSR_ACC_READ  = 2'b00,
      CSR_ACC_WRITE = 2'b01,
      CSR_ACC_SET   = 2'b10,
      CSR_ACC_CLEAR = 2'b11
   } csr_acc_e;

   localparam logic [6:0]  OPC_SYSTEM   = 7'b1110011;
   localparam logic [11:0] ADR_MSTATUS  = 12'h300;
   localparam logic [11:0] ADR_PROT_LO  = 12'h3A0;
   localparam logic [11:0] ADR_PROT_HI  = 12'h3EF;

   // Addresses whose modification must always flush.
   function automatic logic is_mandatory(input logic [11:0] a);
      return (a == ADR_MSTATUS) || ((a >= ADR_PROT_LO) && (a <= ADR_PROT_HI));
   endfunction

endpackage

// File: rtl/csr_instr_decode.sv
module csr_instr_decode
   import csr_flush_pkg::*;
#(
   parameter int unsigned ILEN     = 32,
   parameter int unsigned ADDR_LSB = 20,
   localparam int unsigned ADDR_W  = ILEN - ADDR_LSB
) (
   input  logic [ILEN-1:0]   instr_i,
   output logic              is_csr_o,
   output logic              modifies_o,
   output csr_acc_e          acc_o,
   output logic [ADDR_W-1:0] addr_o
);

   initial begin
      assert (ILEN == 32) else $error("csr_instr_decode: ILEN must be 32");
      assert (ADDR_W == 12) else $error("csr_instr_decode: CSR address must be 12 bits");
   end

   logic [6:0] opcode;
   logic [2:0] funct3;
   logic [4:0] src;
   logic       src_zero;
   logic       is_write_form;

   assign opcode   = instr_i[6:0];
   assign funct3   = instr_i[14:12];
   assign src      = instr_i[19:15];
   assign addr_o   = instr_i[ILEN-1:ADDR_LSB];
   assign src_zero = (src == 5'd0);

   logic unused_rd;
   assign unused_rd = ^instr_i[11:7];

   assign is_csr_o      = (opcode == OPC_SYSTEM) && (funct3[1:0] != 2'b00);
   assign is_write_form = (funct3[1:0] == 2'b01);

   always_comb begin
      modifies_o = 1'b0;
      acc_o      = CSR_ACC_READ;
      if (is_csr_o) begin
         if (is_write_form) begin
            modifies_o = 1'b1;
            acc_o      = CSR_ACC_WRITE;
         end else if (!src_zero) begin
            modifies_o = 1'b1;
            acc_o      = (funct3[1:0] == 2'b10) ? CSR_ACC_SET : CSR_ACC_CLEAR;
         end
      end
   end

endmodule

// File: rtl/csr_flush_filter.sv
module csr_flush_filter
   import csr_flush_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter bit          USE_EXEMPT   = 1'b1,
   parameter int unsigned NUM_EXEMPT   = 2,
   parameter logic [NUM_EXEMPT*ADDR_W-1:0] EXEMPT_ADDRS = {12'h341, 12'h340}
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              flush_needed_o
);

   initial begin
      assert (ADDR_W == 12) else $error("csr_flush_filter: ADDR_W must be 12");
      assert (NUM_EXEMPT >= 1) else $error("csr_flush_filter: NUM_EXEMPT must be at least 1");
   end

   logic mandatory;
   assign mandatory = is_mandatory(addr_i);

   generate
      if (USE_EXEMPT) begin : g_exempt
         logic [NUM_EXEMPT-1:0] hit;
         for (genvar i = 0; i < NUM_EXEMPT; i++) begin : g_entry
            localparam logic [ADDR_W-1:0] ENTRY = EXEMPT_ADDRS[i*ADDR_W +: ADDR_W];
            initial begin
               assert (!is_mandatory(ENTRY))
                  else $warning("csr_flush_filter: exempt entry %0d is a mandatory-flush address", i);
            end
            assign hit[i] = (addr_i == ENTRY);
         end
         assign flush_needed_o = mandatory || (hit == '0);
      end else begin : g_flush_all
         logic unused_mand;
         assign unused_mand    = mandatory;
         assign flush_needed_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/csr_flush_ctrl.sv
module csr_flush_ctrl
   import csr_flush_pkg::*;
#(
   parameter int unsigned ILEN       = 32,
   parameter bit          USE_EXEMPT = 1'b1,
   parameter int unsigned NUM_EXEMPT = 2,
   parameter logic [NUM_EXEMPT*12-1:0] EXEMPT_ADDRS = {12'h341, 12'h340},
   localparam int unsigned ADDR_W    = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ILEN-1:0]   instr_i,
   input  logic              valid_i,
   input  logic              stall_i,
   output logic [1:0]        csr_op_o,
   output logic [ADDR_W-1:0] csr_addr_o,
   output logic              csr_we_o,
   output logic              flush_o
);

   logic              is_csr, modifies, flush_needed, take;
   csr_acc_e          acc;
   logic [ADDR_W-1:0] addr;

   csr_instr_decode #(.ILEN(ILEN), .ADDR_LSB(ILEN - ADDR_W)) u_dec (
      .instr_i   (instr_i),
      .is_csr_o  (is_csr),
      .modifies_o(modifies),
      .acc_o     (acc),
      .addr_o    (addr)
   );

   csr_flush_filter #(
      .ADDR_W      (ADDR_W),
      .USE_EXEMPT  (USE_EXEMPT),
      .NUM_EXEMPT  (NUM_EXEMPT),
      .EXEMPT_ADDRS(EXEMPT_ADDRS)
   ) u_filt (
      .addr_i        (addr),
      .flush_needed_o(flush_needed)
   );

   assign take = valid_i && !stall_i;

   csr_acc_e          acc_q;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q, flush_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q   <= CSR_ACC_READ;
         addr_q  <= '0;
         we_q    <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         we_q    <= take && modifies;
         flush_q <= take && modifies && flush_needed;
         if (take && is_csr) begin
            acc_q  <= acc;
            addr_q <= addr;
         end
      end
   end

   assign csr_op_o   = acc_q;
   assign csr_addr_o = addr_q;
   assign csr_we_o   = we_q;
   assign flush_o    = flush_q;

   // R8/R10: a pulse only follows a cycle where an instruction was taken.
   a_r10_pulse_needs_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_o || csr_we_o) |-> $past(valid_i && !stall_i));
   // R10: a stalled cycle never yields a pulse on the next cycle.
   a_r10_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |=> (!flush_o && !csr_we_o));
   // R7: a flush is always a modification.
   a_r7_flush_has_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> csr_we_o);
   // R4: a reported read never writes.
   a_r4_read_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_we_o) |-> (csr_op_o != CSR_ACC_READ));
   // R6: status and protection writes always flush.
   a_r6_mandatory_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_we_o && is_mandatory(csr_addr_o)) |-> flush_o);
   // R5: default exempt addresses never flush.
   a_r5_exempt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (USE_EXEMPT && EXEMPT_ADDRS == {12'h341, 12'h340} && csr_we_o
       && (csr_addr_o == 12'h340 || csr_addr_o == 12'h341)) |-> !flush_o);

endmodule

// File: tb/csr_flush_ctrl_tb_top.sv
`timescale 1ns/1ps
module csr_flush_ctrl_tb_top;

   typedef struct {
      logic [1:0]  op;
      logic [11:0] addr;
      logic        we;
      logic        flush;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = 32'h0;
   logic        valid = 1'b0;
   logic        stall = 1'b0;
   logic [1:0]  op_o;
   logic [11:0] addr_o;
   logic        we_o, flush_o;

   int vectors = 0;
   int miscompares = 0;
   exp_t sb[$];
   logic [1:0]  last_op = 2'b00;
   logic [11:0] last_addr = 12'h000;

   always #2 clk = ~clk;

   csr_flush_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .valid_i(valid), .stall_i(stall),
      .csr_op_o(op_o), .csr_addr_o(addr_o), .csr_we_o(we_o), .flush_o(flush_o)
   );

   function automatic logic [31:0] enc(input logic [11:0] a, input logic [4:0] s,
                                       input logic [2:0] f3);
      return {a, s, f3, 5'd3, 7'b1110011};
   endfunction

   task automatic check(input string tag, input logic [1:0] op, input logic [11:0] a,
                        input logic we, input logic fl);
      vectors++;
      if (op_o !== op || addr_o !== a || we_o !== we || flush_o !== fl) begin
         miscompares++;
         $display("FAIL %s: got op=%0d addr=%h we=%b flush=%b, expected op=%0d addr=%h we=%b flush=%b",
                  tag, op_o, addr_o, we_o, flush_o, op, a, we, fl);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected registered result.
   task automatic drive(input logic [31:0] w, input logic v, input logic st, input string tag);
      exp_t e;
      logic [2:0]  f3;
      logic        csr, mod, mand, exm;
      @(negedge clk);
      instr = w; valid = v; stall = st;
      f3   = w[14:12];
      csr  = (w[6:0] == 7'h73) && (f3 != 3'b000) && (f3 != 3'b100);
      mod  = csr && ((f3[1:0] == 2'b01) || (w[19:15] != 5'd0));
      mand = (w[31:20] == 12'h300) || (w[31:20] >= 12'h3A0 && w[31:20] <= 12'h3EF);
      exm  = (w[31:20] == 12'h340 || w[31:20] == 12'h341) && !mand;
      if (v && !st && csr) begin
         last_addr = w[31:20];
         last_op   = !mod ? 2'b00 : (f3[1:0] == 2'b01) ? 2'b01 : (f3[1:0] == 2'b10) ? 2'b10 : 2'b11;
      end
      e.op = last_op; e.addr = last_addr;
      e.we = v && !st && mod;
      e.flush = v && !st && mod && !exm;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compares one step after each rising edge.
   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, e.op, e.addr, e.we, e.flush);
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R9 reset", 2'b00, 12'h000, 1'b0, 1'b0);
      rst_n = 1'b1;
      // R3 write forms, zero and nonzero source
      drive(enc(12'h305, 5'd0, 3'b001), 1, 0, "R3 csrrw x0 flushes");
      drive(enc(12'h7C0, 5'd7, 3'b101), 1, 0, "R3 csrrwi imm");
      drive(enc(12'h7C0, 5'd0, 3'b101), 1, 0, "R3 csrrwi zero imm");
      // R4 zero-source set/clear are reads
      drive(enc(12'h3A0, 5'd0, 3'b010), 1, 0, "R4 csrrs x0 read");
      drive(enc(12'h3B5, 5'd0, 3'b011), 1, 0, "R4 csrrc x0 read");
      drive(enc(12'h300, 5'd0, 3'b110), 1, 0, "R4 csrrsi 0 read");
      drive(enc(12'h341, 5'd0, 3'b111), 1, 0, "R4 csrrci 0 read");
      drive(enc(12'h7C1, 5'd1, 3'b010), 1, 0, "R2 R7 set op");
      drive(enc(12'h7C2, 5'd1, 3'b111), 1, 0, "R2 R7 clear imm op");
      // R5 exempt addresses
      drive(enc(12'h340, 5'd9, 3'b001), 1, 0, "R5 scratch write");
      drive(enc(12'h341, 5'd1, 3'b110), 1, 0, "R5 epc set");
      drive(enc(12'h340, 5'd2, 3'b011), 1, 0, "R5 scratch clear");
      // R6 mandatory flush incl. clears
      drive(enc(12'h300, 5'd4, 3'b011), 1, 0, "R6 status clear");
      drive(enc(12'h3A0, 5'd5, 3'b011), 1, 0, "R6 prot cfg low clear");
      drive(enc(12'h3AF, 5'd1, 3'b111), 1, 0, "R6 prot cfg high clri");
      drive(enc(12'h3EF, 5'd2, 3'b001), 1, 0, "R6 prot addr top");
      drive(enc(12'h3B0, 5'd3, 3'b010), 1, 0, "R6 prot addr low");
      drive(enc(12'h3F0, 5'd3, 3'b010), 1, 0, "R7 above prot range");
      drive(enc(12'h39F, 5'd3, 3'b011), 1, 0, "R7 below prot range");
      // R1 non-CSR encodings
      drive(enc(12'h300, 5'd3, 3'b000), 1, 0, "R1 funct3 000");
      drive(enc(12'h300, 5'd3, 3'b100), 1, 0, "R1 funct3 100");
      drive({12'h300, 5'd3, 3'b001, 5'd3, 7'b0110011}, 1, 0, "R1 other opcode");
      // R10 invalid
      drive(enc(12'h300, 5'd3, 3'b001), 0, 0, "R10 invalid");
      // R10/R8 held under stall then released: one pulse
      drive(enc(12'h3C4, 5'd6, 3'b011), 1, 1, "R10 stalled 1");
      drive(enc(12'h3C4, 5'd6, 3'b011), 1, 1, "R10 stalled 2");
      drive(enc(12'h3C4, 5'd6, 3'b011), 1, 1, "R10 stalled 3");
      drive(enc(12'h3C4, 5'd6, 3'b011), 1, 0, "R10 released");
      drive(enc(12'h3C4, 5'd6, 3'b011), 0, 0, "R8 pulse drops");
      drive(32'h0, 0, 0, "R8 hold op addr");
      // R8 back-to-back accepted: two pulses
      drive(enc(12'h300, 5'd1, 3'b001), 1, 0, "R8 b2b first");
      drive(enc(12'h300, 5'd1, 3'b001), 1, 0, "R8 b2b second");
      drive(enc(12'h340, 5'd1, 3'b001), 1, 1, "R10 stalled exempt");
      drive(32'h0, 0, 0, "R8 idle");
      drive(32'h0, 0, 0, "R8 drain");
      @(negedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule